// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Sequencer

This block sits between a host request port and a 1M x 4 extended-data-out DRAM. It takes one word request at a time, with a 20-bit address, a write flag and 4-bit data. It produces the row strobe, column strobe, write strobe, output enable and a shared 10-bit address. The upper ten address bits select the row and go out while the row strobe falls. The lower ten bits select the column and go out while the column strobe falls. Each timing minimum is a parameter counted in clock cycles, rounded up from the device's nanosecond figures for the chosen clock.

After an access, the row stays open. A later request to the same row is served by a column-strobe cycle alone. A request to a different row closes the row first, with a full precharge. The row is also closed when one more page cycle would break the maximum row-low time, or when a separate refresh block raises its bus-hold input. Every write is an early write: the write strobe goes low one cycle before the column strobe falls, so the DRAM never drives its data pins during a write. Read data is captured in the last column-low cycle and returned with a one-cycle valid pulse.

The state machine has seven states. IDLE has the row closed and the device precharged. ROW_OPEN holds the row strobe low for the RAS-to-CAS delay. COL_SETUP places the column, write strobe and data one cycle ahead of the column strobe. CAS_ACT holds the column strobe low. CAS_PRE is the column precharge. PAGE_OPEN keeps the row open and waits. PRECHARGE holds the row strobe high.

The transitions are:
- IDLE to ROW_OPEN when a request is accepted.
- ROW_OPEN to COL_SETUP when the delay timer expires.
- COL_SETUP to CAS_ACT after one cycle.
- CAS_ACT to CAS_PRE when its timer expires.
- CAS_PRE to PAGE_OPEN when its timer expires.
- PAGE_OPEN to COL_SETUP when a page hit is accepted.
- PAGE_OPEN to PRECHARGE on a miss, a full window or a hold, once the minimum row-low time is met.
- PRECHARGE to IDLE when its timer expires.

Top module: `edo_page_seq`

## Requirements
- R1: After reset, ras_n, cas_n, we_n and oe_n are 1, dq_oe and rd_valid are 0, and req_ready is 1 while refresh_hold is 0.
- R2: The row, req_addr[19:10], is on dram_addr when ras_n falls. The column, req_addr[9:0], is on dram_addr when cas_n falls. cas_n falls only while ras_n is low. Data written to an address is read back from that address.
- R3: A request whose row equals the open row, accepted in time, is served with no new fall of ras_n.
- R4: A request to a different row raises ras_n for at least T_RP cycles before the new row falls. req_ready is 0 while ras_n is high in precharge.
- R5: For a write, we_n is low in the cycle before cas_n falls and stays low until cas_n has risen. dq_oe is 1 only while oe_n is 1.
- R6: For a read, we_n stays 1 and oe_n is 0 around the column strobe. rd_data is the DRAM data sampled in the last cas_n-low cycle, shown with a single-cycle rd_valid pulse.
- R7: Each cas_n low pulse lasts T_CAS cycles. cas_n falls at least T_RCD cycles after ras_n falls.
- R8: ras_n stays low for at least T_RAS_MIN and at most T_RAS_MAX cycles. An open row with no traffic is closed by the block itself before the maximum is reached.
- R9: While refresh_hold is 1, req_ready is 0, an open row is closed, and no cas_n pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | 20 | Word address, row in the upper ten bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | 4 | Read data |
| refresh_hold | input | 1 | Refresh block claims the DRAM bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dq_out | output | 4 | Data toward the DRAM |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 4 | Data from the DRAM |

## Verification
In PAGE_OPEN, three things can land in the same cycle: a same-row request that is a page hit, the refresh hold, and an exhausted row window. In that cycle the block must pick between a column cycle and closing the row. The bench sets up a page hit and raises refresh_hold together with a valid request to the open row. It judges the outcome by req_ready staying low, ras_n rising and no column strobe appearing. In a second test the bench leaves the row idle until the window runs out, then expects a fresh row strobe on the next access to the same row.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_COL_SETUP,
        ST_CAS_ACT,
        ST_CAS_PRE,
        ST_PAGE_OPEN,
        ST_PRECHARGE
    } seq_state_t;
endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [ROW_W-1:0]       open_row,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col,
    output logic                   row_hit
);
    assign row     = addr[ROW_W+COL_W-1:COL_W];
    assign col     = addr[COL_W-1:0];
    assign row_hit = (row == open_row);
endmodule

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_ras_window.sv
module edo_ras_window #(
    parameter int T_RAS_MIN = 5,
    parameter int T_RAS_MAX = 40,
    parameter int PAGE_CYC  = 4,
    parameter int CW        = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic min_met,
    output logic room
);
    localparam logic [CW-1:0] SAT = '1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !ras_low)
            cnt <= '0;
        else if (cnt != SAT)
            cnt <= cnt + 1'b1;
    end

    // closing now leaves RAS low for cnt+1 cycles
    assign min_met = (cnt + CW'(1)) >= CW'(T_RAS_MIN);
    // one more page cycle, then a close, must stay within the maximum
    assign room    = (cnt + CW'(PAGE_CYC + 2)) <= CW'(T_RAS_MAX);
endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq
    import edo_seq_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 4,
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 1,
    parameter int T_RP      = 4,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic                   req_we,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   refresh_hold,
    output logic                   ras_n,
    output logic                   cas_n,
    output logic                   we_n,
    output logic                   oe_n,
    output logic [ROW_W-1:0]       dram_addr,
    output logic [DATA_W-1:0]      dq_out,
    output logic                   dq_oe,
    input  logic [DATA_W-1:0]      dq_in
);
    localparam int PAGE_CYC = 1 + T_CAS + T_CP;
    localparam int T_MAXV   = (T_RCD > T_CAS ? T_RCD : T_CAS) > (T_CP > T_RP ? T_CP : T_RP)
                              ? (T_RCD > T_CAS ? T_RCD : T_CAS) : (T_CP > T_RP ? T_CP : T_RP);
    localparam int TW       = $clog2(T_MAXV + 1) + 1;

    seq_state_t st, st_nx;
    logic [ROW_W-1:0]  row_q, req_row;
    logic [COL_W-1:0]  col_q, req_col;
    logic [DATA_W-1:0] wd_q;
    logic              we_q, row_hit, fire;
    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;
    logic              min_met, room, ras_low, acc_cyc;

    edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr(req_addr), .open_row(row_q),
        .row(req_row), .col(req_col), .row_hit(row_hit)
    );

    edo_cycle_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .done(tmr_done)
    );

    edo_ras_window #(.T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX),
                     .PAGE_CYC(PAGE_CYC)) u_window (
        .clk(clk), .rst_n(rst_n), .ras_low(ras_low),
        .min_met(min_met), .room(room)
    );

    // ready depends on the offered row when a row is open
    always_comb begin
        req_ready = 1'b0;
        if (!refresh_hold) begin
            if (st == ST_IDLE)
                req_ready = 1'b1;
            else if (st == ST_PAGE_OPEN)
                req_ready = req_valid && row_hit && room;
        end
    end
    assign fire = req_valid && req_ready;

    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_IDLE:
                if (fire) begin
                    st_nx = ST_ROW_OPEN; tmr_load = 1'b1; tmr_val = TW'(T_RCD - 1);
                end
            ST_ROW_OPEN:
                if (tmr_done) st_nx = ST_COL_SETUP;
            ST_COL_SETUP: begin
                st_nx = ST_CAS_ACT; tmr_load = 1'b1; tmr_val = TW'(T_CAS - 1);
            end
            ST_CAS_ACT:
                if (tmr_done) begin
                    st_nx = ST_CAS_PRE; tmr_load = 1'b1; tmr_val = TW'(T_CP - 1);
                end
            ST_CAS_PRE:
                if (tmr_done) st_nx = ST_PAGE_OPEN;
            ST_PAGE_OPEN:
                if (fire)
                    st_nx = ST_COL_SETUP;
                else if ((refresh_hold || !room || req_valid) && min_met) begin
                    st_nx = ST_PRECHARGE; tmr_load = 1'b1; tmr_val = TW'(T_RP - 1);
                end
            ST_PRECHARGE:
                if (tmr_done) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            row_q <= '0;
            col_q <= '0;
            wd_q  <= '0;
            we_q  <= 1'b0;
        end else begin
            st <= st_nx;
            if (fire) begin
                row_q <= req_row;
                col_q <= req_col;
                wd_q  <= req_wdata;
                we_q  <= req_we;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (st == ST_CAS_ACT) && tmr_done && !we_q;
            if ((st == ST_CAS_ACT) && tmr_done && !we_q)
                rd_data <= dq_in;
        end
    end

    // DRAM pin outputs decoded from the state register
    always_comb begin
        ras_low   = (st != ST_IDLE) && (st != ST_PRECHARGE);
        acc_cyc   = (st == ST_COL_SETUP) || (st == ST_CAS_ACT) || (st == ST_CAS_PRE);
        ras_n     = !ras_low;
        cas_n     = (st != ST_CAS_ACT);
        we_n      = !(acc_cyc && we_q);
        oe_n      = !(acc_cyc && !we_q);
        dq_oe     = acc_cyc && we_q;
        dq_out    = wd_q;
        dram_addr = (st == ST_ROW_OPEN) ? row_q : col_q;
    end
endmodule

// File: rtl/edo_page_seq_chk.sv
module edo_page_seq_chk #(
    parameter int T_CAS     = 2,
    parameter int T_RP      = 4,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic refresh_hold,
    input logic rd_valid,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe
);
    logic [15:0] hi_cnt, lo_cnt, cl_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 16'(T_RP);
            lo_cnt <= '0;
            cl_cnt <= '0;
        end else begin
            hi_cnt <= ras_n ? ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1) : '0;
            lo_cnt <= !ras_n ? ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1) : '0;
            cl_cnt <= !cas_n ? ((cl_cnt == '1) ? cl_cnt : cl_cnt + 1'b1) : '0;
        end
    end

    // R2
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> !ras_n);
    // R5
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> $past(!we_n));
    // R5
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_n) && $past(!we_n)) |-> !we_n);
    // R5
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    // R6
    read_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !oe_n) |-> we_n);
    // R6
    rd_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!cas_n) && !$past(rd_valid)));
    // R4
    precharge_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> !req_ready);
    // R4
    precharge_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_cnt >= 16'(T_RP)));
    // R7
    cas_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (cl_cnt == 16'(T_CAS)));
    // R8
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (lo_cnt < 16'(T_RAS_MAX)));
    // R8
    ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_cnt >= 16'(T_RAS_MIN)));
    // R9
    hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_hold |-> !req_ready);
endmodule

bind edo_page_seq edo_page_seq_chk #(
    .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .refresh_hold(refresh_hold),
    .rd_valid(rd_valid), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dq_oe(dq_oe)
);

// File: tb/edo_page_seq_test.sv
module edo_page_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P_RCD = 2, P_CAS = 2, P_CP = 1, P_RP = 3, P_RMIN = 5, P_RMAX = 40;

    typedef struct packed {
        logic        we;
        logic [19:0] addr;
        logic [3:0]  data;
        logic        newrow;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, {10'd1, 10'd2}, 4'hA, 1'b1},
        '{1'b1, {10'd1, 10'd3}, 4'h5, 1'b0},
        '{1'b0, {10'd1, 10'd2}, 4'hA, 1'b0},
        '{1'b1, {10'd2, 10'd2}, 4'h3, 1'b1},
        '{1'b0, {10'd1, 10'd3}, 4'h5, 1'b1},
        '{1'b0, {10'd2, 10'd2}, 4'h3, 1'b1},
        '{1'b1, {10'd2, 10'd5}, 4'hC, 1'b0},
        '{1'b0, {10'd2, 10'd5}, 4'hC, 1'b0},
        '{1'b0, {10'd1, 10'd2}, 4'hA, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0, refresh_hold = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [3:0] rd_data, dq_out;
    logic [9:0] dram_addr;
    logic [3:0] dq_in;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edo_page_seq #(.T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP), .T_RP(P_RP),
                   .T_RAS_MIN(P_RMIN), .T_RAS_MAX(P_RMAX)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .refresh_hold(refresh_hold),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .dram_addr(dram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // behavioural DRAM, sampled on the falling clock edge
    logic [3:0] mem [0:127];
    logic [9:0] row_l;
    logic [3:0] md = '0;
    logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1;
    int ras_falls = 0, cas_falls = 0, hi_run = 100, ras_lo_run = 0;
    int ew_err = 0, pre_err = 0, fight_err = 0, rcd_err = 0;
    assign dq_in = md;

    initial for (int i = 0; i < 128; i++) mem[i] = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                ras_falls++;
                row_l = dram_addr;
                if (hi_run < P_RP) pre_err++;
                ras_lo_run = 0;
            end
            if (prev_cas && !cas_n) begin
                cas_falls++;
                if (ras_lo_run < P_RCD) rcd_err++;
                if (!we_n) begin
                    if (prev_we) ew_err++;
                    mem[{row_l[2:0], dram_addr[3:0]}] = dq_out;
                end else begin
                    md = mem[{row_l[2:0], dram_addr[3:0]}];
                end
            end
            if (dq_oe && !oe_n) fight_err++;
            if (ras_n) hi_run++; else hi_run = 0;
            if (!ras_n) ras_lo_run++;
        end
        prev_ras = ras_n;
        prev_cas = cas_n;
        prev_we  = we_n;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input logic we, input logic [19:0] a, input logic [3:0] d,
                          output logic [3:0] rdat);
        int c0;
        c0 = cas_falls;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (cas_falls == c0) @(negedge clk);
        rdat = '0;
        if (!we) begin
            while (!rd_valid) @(negedge clk);
            rdat = rd_data;
            @(negedge clk);
            check("R6 single rd_valid pulse", rd_valid, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0] rd;
        int r0, c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ras_n", ras_n, 1);
        check("R1 cas_n", cas_n, 1);
        check("R1 we_n/oe_n", {we_n, oe_n}, 3);
        check("R1 dq_oe/rd_valid", {dq_oe, rd_valid}, 0);
        check("R1 req_ready", req_ready, 1);

        // R2 R3 R4 R5 R6 vector walk
        for (int v = 0; v < 9; v++) begin
            r0 = ras_falls;
            do_req(VECS[v].we, VECS[v].addr, VECS[v].data, rd);
            check(VECS[v].newrow ? "R4 new row opened" : "R3 page hit keeps row",
                  ras_falls - r0, int'(VECS[v].newrow));
            if (!VECS[v].we) check("R2 R6 read data", rd, VECS[v].data);
        end

        // R8 idle row is closed by the window, next same-row access reopens
        repeat (60) @(negedge clk);
        check("R8 row closed after window", ras_n, 1);
        r0 = ras_falls;
        do_req(1'b0, {10'd1, 10'd3}, 4'h0, rd);
        check("R8 reopened row", ras_falls - r0, 1);
        check("R2 read after reopen", rd, 5);

        // R9 hold together with a page hit on the open row
        @(negedge clk);
        refresh_hold = 1'b1;
        req_valid = 1'b1; req_we = 1'b0; req_addr = {10'd1, 10'd2};
        c0 = cas_falls;
        @(negedge clk);
        check("R9 ready low under hold", req_ready, 0);
        repeat (10) @(negedge clk);
        check("R9 row closed under hold", ras_n, 1);
        check("R9 no column strobe", cas_falls - c0, 0);
        check("R9 ready still low", req_ready, 0);
        r0 = ras_falls;
        refresh_hold = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rd_valid) @(negedge clk);
        check("R9 pending read served", rd_data, 10);
        check("R4 row reopened after hold", ras_falls - r0, 1);

        repeat (5) @(negedge clk);
        check("R5 early write violations", ew_err, 0);
        check("R5 data bus fights", fight_err, 0);
        check("R4 precharge violations", pre_err, 0);
        check("R7 ras-to-cas violations", rcd_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule